// File: doc/BRIEF.md
# Dual-Product Montgomery Modular Multiplier

This block computes the Montgomery product of a sum of two products, (A·B + C·D)·R⁻¹ mod P with R = 2^256, as one operation. It is the core step of multiplication in a quadratic extension field over a large odd prime. A field multiplication there needs sums of exactly this form, and fusing the two products avoids a second reduction and a separate modular addition.

Each operand is a 256-bit value held as four 64-bit words. The block scans them word by word in a finely integrated operand-scanning loop. In each outer iteration i, the accumulator takes in a_i·B and c_i·D. The iteration derives one reduction factor m from the low accumulator word and adds m·P during the same inner word loop. The accumulator then moves down by one word.

The modulus and its constant are runtime inputs, so any odd modulus below 2^256 can be used. After the four outer iterations, two conditional subtraction steps bring the value below P. The block is driven with a start/done handshake, and the latency is fixed.

Top module: `dual_mont_mul`

## Requirements
- R1: With odd P, mont_k = −P⁻¹ mod 2^64, and all four operands below P, the result presented with done satisfies result < P and result·2^256 ≡ A·B + C·D (mod P).
- R2: A start seen high at a rising edge while busy is low is accepted. busy is high from that edge on, and done rises exactly 18 rising edges after the accepting edge, with busy still high in that cycle.
- R3: done is high for exactly one cycle per accepted operation, and busy falls at the following edge.
- R4: Operands, modulus and constant are captured only at the accepting edge. A start, or a change on any data input, while busy is high has no effect on the result or on the timing.
- R5: result stays stable from the done cycle until the next accepted start.
- R6: While reset is asserted, and right after it, busy and done are low.
- R7: The same unit gives correct results for several different odd moduli supplied at runtime, including one just below 2^256.
- R8: All-zero operands give result 0. Operands all equal to P−1 give the correct reduced result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation (taken only while idle) |
| op_a | input | 256 | First factor of the first product |
| op_b | input | 256 | Second factor of the first product |
| op_c | input | 256 | First factor of the second product |
| op_d | input | 256 | Second factor of the second product |
| modulus | input | 256 | Odd modulus P |
| mont_k | input | 64 | Constant −P⁻¹ mod 2^64 |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 256 | Reduced Montgomery result |

## Verification
The word-serial loop leaves no intermediate value at the ports. A wrong reduction factor, a dropped carry or a misplaced word write therefore shows only when done rises, 18 cycles after acceptance. It appears there as a result that fails the congruence or is not below P. A wrong sequencer count shows up sooner and cycle-exactly, because busy and done are compared with a reference model on every clock. A missing final subtraction shows as a result of P or more, and this is most likely with large operands and with moduli close to 2^256.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SUB  = 2'd2,
    ST_FIN  = 2'd3
  } dmm_state_e;
endpackage

// File: rtl/dmm_qfactor.sv
// Reduction factor for one outer iteration: low word of the new column-0
// sum times the Montgomery constant, all modulo 2^W.
module dmm_qfactor #(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0] t0,
  input  logic [WORD_W-1:0] a_w,
  input  logic [WORD_W-1:0] b0,
  input  logic [WORD_W-1:0] c_w,
  input  logic [WORD_W-1:0] d0,
  input  logic [WORD_W-1:0] kinv,
  output logic [WORD_W-1:0] m
);
  logic [WORD_W-1:0] u;

  always_comb begin
    u = t0 + a_w * b0 + c_w * d0;
    m = u * kinv;
  end
endmodule

// File: rtl/dmm_word_mac.sv
// One inner column step: t + a*b + c*d + m*p + carry.
module dmm_word_mac #(
  parameter int WORD_W = 64,
  parameter int CAR_W  = WORD_W + 2
) (
  input  logic [WORD_W-1:0] t_w,
  input  logic [WORD_W-1:0] a_w,
  input  logic [WORD_W-1:0] b_w,
  input  logic [WORD_W-1:0] c_w,
  input  logic [WORD_W-1:0] d_w,
  input  logic [WORD_W-1:0] m_w,
  input  logic [WORD_W-1:0] p_w,
  input  logic [CAR_W-1:0]  car_in,
  output logic [WORD_W-1:0] lo,
  output logic [CAR_W-1:0]  car_out
);
  localparam int SUM_W = WORD_W + CAR_W;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(t_w)
        + SUM_W'(a_w) * SUM_W'(b_w)
        + SUM_W'(c_w) * SUM_W'(d_w)
        + SUM_W'(m_w) * SUM_W'(p_w)
        + SUM_W'(car_in);
    lo      = sum[WORD_W-1:0];
    car_out = sum[SUM_W-1:WORD_W];
  end
endmodule

// File: rtl/dmm_cond_sub.sv
// Subtract the modulus once if the value is not below it.
module dmm_cond_sub #(
  parameter int OP_W  = 256,
  parameter int EXT_W = 2
) (
  input  logic [OP_W+EXT_W-1:0] val,
  input  logic [OP_W-1:0]       modulus,
  output logic [OP_W+EXT_W-1:0] val_out
);
  logic [OP_W+EXT_W-1:0] mod_ext;

  always_comb begin
    mod_ext = {{EXT_W{1'b0}}, modulus};
    val_out = (val >= mod_ext) ? (val - mod_ext) : val;
  end
endmodule

// File: rtl/dual_mont_mul.sv
module dual_mont_mul
  import dmm_pkg::*;
#(
  parameter int  WORD_W    = 64,
  parameter int  NWORDS    = 4,
  parameter int  SUB_STEPS = 2,
  localparam int OP_W      = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [OP_W-1:0]   op_c,
  input  logic [OP_W-1:0]   op_d,
  input  logic [OP_W-1:0]   modulus,
  input  logic [WORD_W-1:0] mont_k,
  output logic              busy,
  output logic              done,
  output logic [OP_W-1:0]   result
);
  localparam int EXT_W = 2;
  localparam int CAR_W = WORD_W + EXT_W;
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int SBC_W = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);
  localparam logic [SBC_W-1:0] LAST_SUB = SBC_W'(SUB_STEPS - 1);

  typedef logic [NWORDS-1:0][WORD_W-1:0] words_t;

  // control state
  dmm_state_e       state_q, state_d;
  logic [IDX_W-1:0] i_q, i_d, j_q, j_d;
  logic [SBC_W-1:0] sub_q, sub_d;

  // datapath state
  words_t            a_q, b_q, c_q, d_q, p_q;
  logic [WORD_W-1:0] k_q;
  words_t            t_q, t_d;
  logic [EXT_W-1:0]  t_ext_q, t_ext_d;
  logic [WORD_W-1:0] m_q, m_d;
  logic [CAR_W-1:0]  car_q, car_d;

  logic              op_ld, work_en;
  logic [WORD_W-1:0] m_new, m_use, mac_lo;
  logic [CAR_W-1:0]  car_use, mac_car, ext_sum;
  logic [OP_W+EXT_W-1:0] sub_val;

  assign op_ld   = (state_q == ST_IDLE) && start;
  assign work_en = op_ld || (state_q == ST_MUL) || (state_q == ST_SUB);

  assign m_use   = (j_q == '0) ? m_new : m_q;
  assign car_use = (j_q == '0) ? '0 : car_q;
  assign ext_sum = CAR_W'(t_ext_q) + mac_car;

  dmm_qfactor #(.WORD_W(WORD_W)) u_qfactor (
    .t0   (t_q[0]),
    .a_w  (a_q[i_q]),
    .b0   (b_q[0]),
    .c_w  (c_q[i_q]),
    .d0   (d_q[0]),
    .kinv (k_q),
    .m    (m_new)
  );

  dmm_word_mac #(.WORD_W(WORD_W), .CAR_W(CAR_W)) u_mac (
    .t_w     (t_q[j_q]),
    .a_w     (a_q[i_q]),
    .b_w     (b_q[j_q]),
    .c_w     (c_q[i_q]),
    .d_w     (d_q[j_q]),
    .m_w     (m_use),
    .p_w     (p_q[j_q]),
    .car_in  (car_use),
    .lo      (mac_lo),
    .car_out (mac_car)
  );

  dmm_cond_sub #(.OP_W(OP_W), .EXT_W(EXT_W)) u_csub (
    .val     ({t_ext_q, t_q}),
    .modulus (p_q),
    .val_out (sub_val)
  );

  // next state
  always_comb begin
    state_d = state_q;
    i_d     = i_q;
    j_d     = j_q;
    sub_d   = sub_q;
    t_d     = t_q;
    t_ext_d = t_ext_q;
    m_d     = m_q;
    car_d   = car_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          t_d     = '0;
          t_ext_d = '0;
          i_d     = '0;
          j_d     = '0;
          state_d = ST_MUL;
        end
      end
      ST_MUL: begin
        if (j_q == '0) m_d = m_new;
        car_d = mac_car;
        if (j_q != '0) t_d[j_q - 1'b1] = mac_lo;
        if (j_q == LAST_IDX) begin
          t_d[LAST_IDX] = ext_sum[WORD_W-1:0];
          t_ext_d       = ext_sum[CAR_W-1:WORD_W];
          j_d           = '0;
          if (i_q == LAST_IDX) begin
            sub_d   = '0;
            state_d = ST_SUB;
          end else begin
            i_d = i_q + 1'b1;
          end
        end else begin
          j_d = j_q + 1'b1;
        end
      end
      ST_SUB: begin
        {t_ext_d, t_d} = sub_val;
        sub_d = sub_q + 1'b1;
        if (sub_q == LAST_SUB) state_d = ST_FIN;
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      sub_q   <= '0;
    end else begin
      state_q <= state_d;
      i_q     <= i_d;
      j_q     <= j_d;
      sub_q   <= sub_d;
    end
  end

  // datapath registers, enabled only
  always_ff @(posedge clk) begin
    if (op_ld) begin
      a_q <= op_a;
      b_q <= op_b;
      c_q <= op_c;
      d_q <= op_d;
      p_q <= modulus;
      k_q <= mont_k;
    end
    if (work_en) begin
      t_q     <= t_d;
      t_ext_q <= t_ext_d;
      m_q     <= m_d;
      car_q   <= car_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);
  assign result = t_q;
endmodule

// File: rtl/dual_mont_mul_chk.sv
module dual_mont_mul_chk #(
  parameter int  WORD_W = 64,
  parameter int  NWORDS = 4,
  localparam int OP_W   = WORD_W * NWORDS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [OP_W-1:0] result,
  input logic [OP_W-1:0] p_q,
  input logic [1:0]      t_ext_q
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R2
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R1
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < p_q));

  // R1
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (t_ext_q != 2'b11));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind dual_mont_mul dual_mont_mul_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .p_q     (p_q),
  .t_ext_q (t_ext_q)
);

// File: tb/dual_mont_mul_bench.sv
`timescale 1ns/1ps
module dual_mont_mul_bench;
  localparam int W   = 64;
  localparam int OPW = 256;
  localparam int LAT = 18;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [OPW-1:0] op_a, op_b, op_c, op_d, modulus;
  logic [W-1:0]   mont_k;
  logic           busy, done;
  logic [OPW-1:0] result;

  dual_mont_mul u_dual_mont_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .modulus(modulus), .mont_k(mont_k),
    .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  integer n_chk = 0;
  integer n_err = 0;
  string  cur_tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [OPW-1:0] act, input logic [OPW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calc_k(input logic [OPW-1:0] p);
    logic [W-1:0] p0, x;
    p0 = p[W-1:0];
    x  = p0;
    for (int n = 0; n < 6; n++) x = x * (64'd2 - p0 * x);
    return -x;
  endfunction

  // reference model: cycle position and captured operands
  integer         mc;
  logic [OPW-1:0] ea, eb, ec, ed, ep;
  logic [OPW-1:0] held;
  bit             have_held;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc = 0;
    else if (mc == 0 && start) begin
      mc = 1;
      ea = op_a; eb = op_b; ec = op_c; ed = op_d; ep = modulus;
    end else if (mc == LAT + 1) mc = 0;
    else if (mc > 0) mc = mc + 1;
  end

  always @(negedge clk) begin
    logic [767:0] lhs, rhs;
    chk(busy == (mc != 0), "R2", "busy", OPW'(busy), OPW'(mc != 0));
    chk(done == (mc == LAT + 1), "R3", "done", OPW'(done), OPW'(mc == LAT + 1));
    if (mc == LAT + 1) begin
      lhs = ({512'b0, result} << 256) % {512'b0, ep};
      rhs = ({512'b0, ea} * {512'b0, eb} + {512'b0, ec} * {512'b0, ed}) % {512'b0, ep};
      chk(lhs == rhs, cur_tag, "congruence", lhs[OPW-1:0], rhs[OPW-1:0]);
      chk(result < ep, cur_tag, "range", result, ep);
      held      = result;
      have_held = 1'b1;
    end else if (mc == 0 && have_held && rst_n) begin
      chk(result == held, "R5", "hold", result, held);
    end
  end

  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input logic [OPW-1:0] c, input logic [OPW-1:0] d,
                        input logic [OPW-1:0] p, input string tag, input bit disturb);
    @(negedge clk);
    cur_tag = tag;
    op_a = a; op_b = b; op_c = c; op_d = d; modulus = p;
    mont_k = calc_k(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (4) @(negedge clk);
      op_a = ~a; op_b = b ^ 256'h5a; op_c = 256'd7; op_d = ~d;
      modulus = p - 256'd2; mont_k = ~mont_k;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT - 4) @(negedge clk);
    end else begin
      repeat (LAT + 1) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [OPW-1:0] rnd(input logic [OPW-1:0] p);
    logic [OPW-1:0] v;
    for (int n = 0; n < 8; n++) v[n*32 +: 32] = $urandom;
    return v % p;
  endfunction

  localparam logic [OPW-1:0] P_A = 256'hB640000002A3A6F1D603AB4FF58EC74521F2934B1A7AEEDBE56F9B27E351457D;
  localparam logic [OPW-1:0] P_B = 256'h7FFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFED;
  localparam logic [OPW-1:0] P_C = 256'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF43;

  integer cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    have_held = 1'b0;
    rst_n = 1'b0; start = 1'b0;
    op_a = '0; op_b = '0; op_c = '0; op_d = '0; modulus = P_A; mont_k = '0;
    repeat (3) @(negedge clk);
    // R6: outputs idle during reset
    chk(!busy && !done, "R6", "reset outputs", OPW'({busy, done}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R6", "after reset", OPW'({busy, done}), '0);

    // R8: zeros and maxima
    run_op('0, '0, '0, '0, P_A, "R8", 1'b0);
    chk(result == '0, "R8", "zero operands", result, '0);
    run_op(P_A - 1, P_A - 1, P_A - 1, P_A - 1, P_A, "R8", 1'b0);
    run_op(256'd1, 256'd1, 256'd0, 256'd5, P_A, "R1", 1'b0);

    // R1 / R7: random operands over several moduli
    for (int n = 0; n < 4; n++) run_op(rnd(P_A), rnd(P_A), rnd(P_A), rnd(P_A), P_A, "R1", 1'b0);
    for (int n = 0; n < 4; n++) run_op(rnd(P_B), rnd(P_B), rnd(P_B), rnd(P_B), P_B, "R7", 1'b0);
    for (int n = 0; n < 4; n++) run_op(rnd(P_C), rnd(P_C), rnd(P_C), rnd(P_C), P_C, "R7", 1'b0);
    run_op(P_C - 1, P_C - 1, P_C - 1, P_C - 1, P_C, "R7", 1'b0);

    // R4: start and input changes while busy
    run_op(rnd(P_A), rnd(P_A), rnd(P_A), rnd(P_A), P_A, "R4", 1'b1);
    run_op(rnd(P_C), rnd(P_C), rnd(P_C), rnd(P_C), P_C, "R4", 1'b1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule